// File: doc/BRIEF.md
# Power-of-Two Clock Post-Divider with Output Gating

This block sits behind a clock generator. It picks one of two incoming clocks, either the synthesized clock or the reference clock, and divides it by 1, 2, 4, 8, 16, 32, 64 or 128. A three-bit code selects the ratio. Code 0 passes the selected clock through unchanged. Codes 1 to 7 take one bit of a free-running binary counter, so every divided output has an even duty cycle.

One shared control pin gates the output. Configuration makes the pin either an output enable (high enables) or a power-down request (low powers down). In both functions the pin idles high. In power-down the divider counter is cleared and held at zero. As an output enable, the pin gates only the output and the counter keeps its phase. A timing-mode bit chooses how the gate reacts. In asynchronous mode the output drops at once when the pin goes low. In synchronous mode the high phase in progress runs to its full width, and a restart always begins with a complete high phase. While the block is disabled the output stays low.

Top module: `clkdiv_top`

## Requirements
- R1: Divide code k in 1..7 gives an output period of 2^k selected-clock cycles, high for exactly 2^(k-1) of them.
- R2: Source select 0 takes the synthesized clock and 1 takes the reference clock as the divider input.
- R3: Divide code 0 passes the selected clock through, high while that clock is high, subject to gating.
- R4: Control function 0 makes the pin an output enable (high = running). Function 1 makes it a power-down (low = powered down). While disabled the output is low.
- R5: With timing mode 1 (asynchronous), the output goes low at once when the pin falls. When the pin rises, the output at once follows the divider again.
- R6: With timing mode 0 (synchronous), a pin fall during a high phase lets that phase finish at full width before the output goes low.
- R7: With timing mode 0, the first high phase after re-enable is a full 2^(k-1) cycles, with no runt pulse.
- R8: In power-down the counter is held at zero, so after release the first rising output edge comes 2^(k-1) selected-clock edges after the release. As an output enable the counter runs on, so output edges stay on their original grid.
- R9: A change of source select or divide code clears the counter, forces the output low and restarts the divider.
- R10: While the active-low reset is asserted the output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| syn_clk | input | 1 | Synthesized clock source |
| ref_clk | input | 1 | Reference clock source |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_sel | input | 1 | Divider input: 0 synthesized, 1 reference |
| div_code | input | CODE_W | Ratio exponent; 0 is pass-through |
| ctl_fn | input | 1 | Pin function: 0 output enable, 1 power-down |
| ctl_async | input | 1 | Gate timing: 1 asynchronous, 0 synchronous |
| ctl_pin | input | 1 | Shared control pin, idle high |
| clk_out | output | 1 | Divided, gated clock |

## Verification
The bench disables the output partway through a high phase in synchronous mode. A design that gates combinationally would clip that phase or leave a runt pulse when the output is re-enabled at an arbitrary phase. Power-down release is timed against output-enable re-enable, which shows whether the counter was really cleared or only masked. A mid-phase change of divide code has to give a low output followed by a clean restart. A design that kept the old count would show a short first period. The reference-clock ratio is measured in reference cycles, and the pass-through case is sampled in both clock phases, so the bench also catches a wrong source selection.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic {
    CTL_OE = 1'b0,
    CTL_PD = 1'b1
  } ctl_fn_e;

  // Output period, in source cycles, for a given ratio exponent.
  function automatic int unsigned period_of(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // Width of the high phase for a divided ratio (code >= 1).
  function automatic int unsigned high_of(input int unsigned code);
    return (code == 0) ? 32'd0 : (32'd1 << (code - 1));
  endfunction

endpackage

// File: rtl/clkdiv_src_mux.sv
module clkdiv_src_mux (
  input  logic syn_clk,
  input  logic ref_clk,
  input  logic src_sel,
  output logic sclk
);
  // Static configuration select; a change also restarts the divider.
  assign sclk = src_sel ? ref_clk : syn_clk;
endmodule

// File: rtl/clkdiv_pow2.sv
module clkdiv_pow2 #(
  parameter int CODE_W = 3
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              src_sel,
  input  logic [CODE_W-1:0] code,
  input  logic              hold,
  output logic              div_q,
  output logic              div_nxt,
  output logic              cfg_chg
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CODE_W:0]   cfg_q;

  function automatic logic tap_bit(input logic [CNT_W-1:0] v,
                                   input logic [CODE_W-1:0] c);
    logic r;
    r = 1'b0;
    for (int i = 1; i <= CNT_W; i++)
      if (c == CODE_W'(i)) r = v[i-1];
    return r;
  endfunction

  assign cfg_chg = (cfg_q != {src_sel, code});
  assign cnt_d   = (cfg_chg || hold) ? '0 : cnt_q + CNT_W'(1);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cfg_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cfg_q <= {src_sel, code};
    end
  end

  assign div_q   = tap_bit(cnt_q, code);
  assign div_nxt = tap_bit(cnt_d, code);

  // R8: power-down clears the counter
  a_r8_hold_clears: assert property (@(posedge sclk) disable iff (!rst_n)
    hold |=> (cnt_q == '0));

  // R9: configuration change restarts from a low level
  a_r9_cfg_restart: assert property (@(posedge sclk) disable iff (!rst_n)
    cfg_chg |=> (cnt_q == '0 && !div_q));

endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate #(
  parameter int CODE_W = 3
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              async_mode,
  input  logic              want,
  input  logic              div_q,
  input  logic              div_nxt,
  output logic              clk_o,
  output logic              gate_open
);
  logic is_pass;
  logic gate_q, gate_nxt, out_q, en_neg;

  assign is_pass = (code == '0);

  // Gate may only change outside a continuing high phase.
  assign gate_nxt = (div_q && div_nxt) ? gate_q : want;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      gate_q <= gate_nxt;
      out_q  <= div_nxt & gate_nxt;
    end
  end

  // Pass-through gate enable changes only while the source is low.
  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) en_neg <= 1'b0;
    else        en_neg <= want;
  end

  assign gate_open = is_pass ? en_neg : gate_q;

  always_comb begin
    if (async_mode) clk_o = (is_pass ? sclk : div_q) & want;
    else            clk_o = is_pass ? (sclk & en_neg) : out_q;
  end

  // R6: an open high phase is never cut short in synchronous mode
  a_r6_high_completes: assert property (@(posedge sclk) disable iff (!rst_n)
    (!async_mode && !is_pass && out_q && div_q && div_nxt) |=> out_q);

  // R7: the output rises only where the divider phase begins
  a_r7_clean_start: assert property (@(posedge sclk) disable iff (!rst_n)
    (!async_mode && !is_pass && $stable(code) && $rose(out_q))
      |-> (div_q && !$past(div_q)));

endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
  import clkdiv_pkg::*;
#(
  parameter int CODE_W = 3
) (
  input  logic              syn_clk,
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              src_sel,
  input  logic [CODE_W-1:0] div_code,
  input  logic              ctl_fn,
  input  logic              ctl_async,
  input  logic              ctl_pin,
  output logic              clk_out
);
  logic sclk, want, hold, pd_mode;
  logic div_q, div_nxt, cfg_chg, gate_open, gated;

  // Both pin functions idle high: high means running.
  assign want    = ctl_pin;
  assign pd_mode = (ctl_fn == CTL_PD);
  assign hold    = pd_mode && !want && (ctl_async || !gate_open);

  clkdiv_src_mux u_mux (
    .syn_clk (syn_clk),
    .ref_clk (ref_clk),
    .src_sel (src_sel),
    .sclk    (sclk)
  );

  clkdiv_pow2 #(.CODE_W(CODE_W)) u_div (
    .sclk    (sclk),
    .rst_n   (rst_n),
    .src_sel (src_sel),
    .code    (div_code),
    .hold    (hold),
    .div_q   (div_q),
    .div_nxt (div_nxt),
    .cfg_chg (cfg_chg)
  );

  clkdiv_gate #(.CODE_W(CODE_W)) u_gate (
    .sclk       (sclk),
    .rst_n      (rst_n),
    .code       (div_code),
    .async_mode (ctl_async),
    .want       (want),
    .div_q      (div_q),
    .div_nxt    (div_nxt),
    .clk_o      (gated),
    .gate_open  (gate_open)
  );

  assign clk_out = gated & rst_n;

  // R5: asynchronous disable keeps the output low
  a_r5_async_low: assert property (@(negedge sclk) disable iff (!rst_n)
    (ctl_async && !ctl_pin) |-> !clk_out);

endmodule

// File: tb/clkdiv_top_bench.sv
module clkdiv_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int REF_PERIOD = 26;

  logic syn_clk = 1'b0, ref_clk = 1'b0;
  logic rst_n, src_sel, ctl_fn, ctl_async, ctl_pin;
  logic [2:0] div_code;
  logic clk_out;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) syn_clk = ~syn_clk;
  always #(REF_PERIOD/2) ref_clk = ~ref_clk;

  clkdiv_top u_clkdiv_top (
    .syn_clk(syn_clk), .ref_clk(ref_clk), .rst_n(rst_n), .src_sel(src_sel),
    .div_code(div_code), .ctl_fn(ctl_fn), .ctl_async(ctl_async),
    .ctl_pin(ctl_pin), .clk_out(clk_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One sample per selected-source cycle, 1 ns after its rising edge.
  task automatic samp(output logic s);
    if (src_sel) @(posedge ref_clk); else @(posedge syn_clk);
    #1;
    s = clk_out;
  endtask

  task automatic find_rise(input string req);
    logic p, s;
    p = 1'b1;
    for (int i = 0; i < 1000; i++) begin
      samp(s);
      if (!p && s) return;
      p = s;
    end
    chk(1'b0, req, 0, 1);
  endtask

  task automatic measure(input string req, output int per, output int hi);
    logic p, s;
    find_rise(req);
    per = 1; hi = 1; p = 1'b1;
    for (int i = 0; i < 1000; i++) begin
      samp(s);
      if (s && !p) return;
      per++;
      if (s) hi++;
      p = s;
    end
  endtask

  task automatic t_reset();
    logic s;
    int bad = 0;
    for (int i = 0; i < 6; i++) begin samp(s); if (s) bad++; end
    chk(bad == 0, "R10 reset low", bad, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_ratios();
    int per, hi;
    ctl_async = 1'b0; ctl_fn = 1'b0; ctl_pin = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      div_code = 3'(k);
      measure("R1", per, hi);
      chk(per == (1 << k), "R1 period", per, 1 << k);
      chk(hi == (1 << (k-1)), "R1 high width", hi, 1 << (k-1));
    end
  endtask

  task automatic t_pass();
    logic s;
    int bad = 0;
    div_code = 3'd0;
    samp(s); samp(s);
    for (int i = 0; i < 8; i++) begin
      samp(s); if (!s) bad++;
      #5; if (clk_out) bad++;
    end
    chk(bad == 0, "R3 pass-through", bad, 0);
    ctl_pin = 1'b0;
    samp(s); samp(s);
    bad = 0;
    for (int i = 0; i < 8; i++) begin samp(s); if (s) bad++; end
    chk(bad == 0, "R4 pass-through disabled low", bad, 0);
    ctl_pin = 1'b1;
  endtask

  task automatic t_async();
    logic s;
    int bad = 0;
    div_code = 3'd4; ctl_async = 1'b1;
    find_rise("R5");
    ctl_pin = 1'b0;
    #1;
    chk(clk_out == 1'b0, "R5 immediate low", clk_out, 0);
    for (int i = 1; i <= 34; i++) begin samp(s); if (s) bad++; end
    chk(bad == 0, "R4 held low while disabled", bad, 0);
    ctl_pin = 1'b1;
    #1;
    chk(clk_out == 1'b1, "R5 R8 immediate resume on free-running grid", clk_out, 1);
  endtask

  task automatic t_sync();
    logic s;
    int hi, bad;
    div_code = 3'd3; ctl_async = 1'b0;
    find_rise("R6");
    ctl_pin = 1'b0;
    hi = 1;
    for (int i = 0; i < 20; i++) begin samp(s); if (!s) break; hi++; end
    chk(hi == 4, "R6 high phase completes", hi, 4);
    bad = 0;
    for (int i = 0; i < 21; i++) begin samp(s); if (s) bad++; end
    chk(bad == 0, "R4 sync disabled low", bad, 0);
    ctl_pin = 1'b1;
    find_rise("R7");
    hi = 1;
    for (int i = 0; i < 20; i++) begin samp(s); if (!s) break; hi++; end
    chk(hi == 4, "R7 first high full width", hi, 4);
  endtask

  task automatic t_pd();
    logic s;
    int bad = 0, first = -1;
    ctl_fn = 1'b1; ctl_async = 1'b0; div_code = 3'd4;
    ctl_pin = 1'b0;
    for (int i = 0; i < 40; i++) begin samp(s); if (i >= 12 && s) bad++; end
    chk(bad == 0, "R4 power-down low", bad, 0);
    ctl_pin = 1'b1;
    for (int i = 1; i <= 40; i++) begin
      samp(s);
      if (s) begin first = i; break; end
    end
    chk(first == 8, "R8 restart from cleared counter", first, 8);
    ctl_fn = 1'b0;
  endtask

  task automatic t_cfg();
    logic s1, s2, s3;
    int per, hi;
    div_code = 3'd5;
    find_rise("R9");
    samp(s1); samp(s1);
    div_code = 3'd2;
    samp(s1); samp(s2); samp(s3);
    chk(s1 == 1'b0, "R9 low after code change", s1, 0);
    chk(s2 == 1'b0, "R9 still low", s2, 0);
    chk(s3 == 1'b1, "R9 restart high", s3, 1);
    measure("R9", per, hi);
    chk(per == 4 && hi == 2, "R9 new ratio", per * 10 + hi, 42);
  endtask

  task automatic t_src();
    int per, hi;
    src_sel = 1'b1; div_code = 3'd3;
    measure("R2", per, hi);
    chk(per == 8, "R2 reference period", per, 8);
    chk(hi == 4, "R2 reference high width", hi, 4);
  endtask

  initial begin
    rst_n = 1'b0; src_sel = 1'b0; div_code = 3'd0;
    ctl_fn = 1'b0; ctl_async = 1'b1; ctl_pin = 1'b1;
    t_reset();
    t_ratios();
    t_pass();
    t_async();
    t_sync();
    t_pd();
    t_cfg();
    t_src();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule